// File: doc/BRIEF.md
# Countdown Watchdog with Seconds or Minutes Units

This block is a countdown watchdog that sits behind a small byte-wide register file. Software selects whether the count advances once per second or once per minute, programs a 16-bit reload value as two bytes, and starts the countdown by writing the low byte. While the count is running it drops by one on every timebase step. When it reaches zero it stops, raises a sticky expiry flag and, if enabled, drives one or both reset outputs.

Two bus activity strobes can act as keepalive sources: a write to an infrared data port and a read of a game port. Each has its own enable bit in the control register. A keepalive does not reload the counter at once. It reloads the count from the value registers a fixed number of clock cycles later, and that number is a parameter. A force bit makes the next clock behave as an expiry. A parameter selects an 8-bit variant that has no high byte. The one-second tick is supplied from outside the block.

Top module: `wdu_top`

## Requirements
- R1: The control register sits at address 0x71, configuration at 0x72, count low byte at 0x73 and count high byte at 0x74. When `reg_rd` is high, `reg_rdata` returns the addressed register. Any other address, or `reg_rd` low, returns 0. All registers reset to 0. The configuration register reads back all 8 bits as written, including the interrupt-select field in bits 3:0, which affects nothing else.
- R2: When configuration bit 7 is 1 (seconds), a running count of N expires on the Nth `tick_1s` pulse after the load. A count that has reached zero stays stopped, and further ticks cause no new expiry.
- R3: When configuration bit 7 is 0 (minutes), ticks are divided by 60, so a count of N expires on the (60*N)th tick after the load.
- R4: A write to the low byte loads the count with {high byte register, written byte} and clears the minute prescaler. A nonzero value starts the countdown. A zero value stops it, and no number of ticks then causes an expiry.
- R5: Control bit 0 is set by an expiry and stays set. A control write with bit 0 = 0 clears it. A control write with bit 0 = 1 leaves it unchanged.
- R6: Writing control bit 1 = 1 turns the next clock edge into an expiry: the flag sets and the count stops. Control bit 1 then reads back as 0.
- R7: With control bit 7 = 1, a `kick_ir_wr` pulse reloads the count from {high, low} registers and clears the prescaler exactly KICK_DLY clock cycles later, but only if the count is still nonzero at that time. Control bit 4 = 1 does the same for `kick_gp_rd`. A pulse whose enable bit is 0 is ignored. Ticks arriving during the delay still decrement the old count.
- R8: `wdt_rst` equals flag AND configuration bit 6. `wdt_pg_rst` equals flag AND configuration bit 4. With both bits clear, an expiry sets only the flag.
- R9: With NARROW = 1, writes to the high byte are ignored, the high byte reads 0, and the count is the 8-bit low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (0 when not reading) |
| kick_ir_wr | input | 1 | Keepalive event: infrared data port write |
| kick_gp_rd | input | 1 | Keepalive event: game port read |
| wdt_rst | output | 1 | Reset output on expiry |
| wdt_pg_rst | output | 1 | Power-good reset output on expiry |

## Verification
The table-driven part loads counts in both unit modes and applies one tick fewer than the count needs, then exactly the number it needs. This separates an off-by-one in the decrement or in the divide-by-60 from correct expiry timing. The vectors use counts that need the high byte, a zero count, and each combination of the two reset enables, which separates the flag from the reset outputs. Directed keepalive tests put a tick inside the reload delay and another after it. This shows that the reload is delayed and not immediate, that a disabled source is ignored, and that an expired counter is not restarted. A second instance built as the narrow variant shows that a high-byte write does not reach the count.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
    // Register addresses (decoded by neighbouring logic, so kept fixed)
    localparam logic [7:0] ADDR_CTRL = 8'h71;
    localparam logic [7:0] ADDR_CFG  = 8'h72;
    localparam logic [7:0] ADDR_LO   = 8'h73;
    localparam logic [7:0] ADDR_HI   = 8'h74;

    // Bit positions
    localparam int CFG_SEC_B   = 7;
    localparam int CFG_RST_B   = 6;
    localparam int CFG_PG_B    = 4;
    localparam int CTRL_IRK_B  = 7;
    localparam int CTRL_GPK_B  = 4;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef struct packed {
        logic [5:0] ctrl_up;   // control bits 7:2 as written
        logic       frc;       // force-expiry request
        logic       flag;      // sticky expiry flag
        logic [7:0] cfg;
        logic [7:0] lo;
        logic [7:0] hi;
    } wdu_regs_t;
endpackage

// File: rtl/wdu_regs.sv
module wdu_regs
    import wdu_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             expire_i,
    output logic [7:0]       rdata,
    output logic             irk_en_o,
    output logic             gpk_en_o,
    output logic             sec_mode_o,
    output logic             rst_en_o,
    output logic             pg_en_o,
    output logic             force_o,
    output logic             flag_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic [CNT_W-1:0] reload_val_o
);
    wdu_regs_t r_d, r_q;
    logic wr_ctrl, wr_cfg, wr_lo, wr_hi;

    always_comb begin
        wr_ctrl = wr && (addr == ADDR_CTRL);
        wr_cfg  = wr && (addr == ADDR_CFG);
        wr_lo   = wr && (addr == ADDR_LO);
        wr_hi   = wr && (addr == ADDR_HI) && !NARROW;

        r_d     = r_q;
        r_d.frc = 1'b0;
        if (wr_ctrl) begin
            r_d.ctrl_up = wdata[7:2];
            r_d.frc     = wdata[1];
            if (!wdata[0]) r_d.flag = 1'b0;
        end
        if (wr_cfg) r_d.cfg = wdata;
        if (wr_lo)  r_d.lo  = wdata;
        if (wr_hi)  r_d.hi  = wdata;
        if (expire_i) r_d.flag = 1'b1;

        rdata = '0;
        if (rd) begin
            case (addr)
                ADDR_CTRL: rdata = {r_q.ctrl_up, r_q.frc, r_q.flag};
                ADDR_CFG:  rdata = r_q.cfg;
                ADDR_LO:   rdata = r_q.lo;
                ADDR_HI:   rdata = r_q.hi;
                default:   rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irk_en_o     = r_q.ctrl_up[CTRL_IRK_B-2];
    assign gpk_en_o     = r_q.ctrl_up[CTRL_GPK_B-2];
    assign sec_mode_o   = r_q.cfg[CFG_SEC_B];
    assign rst_en_o     = r_q.cfg[CFG_RST_B];
    assign pg_en_o      = r_q.cfg[CFG_PG_B];
    assign force_o      = r_q.frc;
    assign flag_o       = r_q.flag;
    assign load_o       = wr_lo;
    assign load_val_o   = {r_q.hi, wdata};
    assign reload_val_o = {r_q.hi, r_q.lo};

    // R5: flag holds unless a control write clears bit 0
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !(wr_ctrl && !wdata[0])) |=> r_q.flag);
    // R6: a force request lasts one cycle unless rewritten, and yields the flag
    assert_force_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.frc && !(wr_ctrl && wdata[1])) |=> !r_q.frc);
    assert_force_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.frc |=> r_q.flag);
    // R9: narrow variant keeps high byte at zero
    assert_narrow_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (NARROW && wr && addr == ADDR_HI) |=> (r_q.hi == 8'h00));
endmodule

// File: rtl/wdu_kick_delay.sv
module wdu_kick_delay #(
    parameter int KICK_DLY = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic fire_o
);
    localparam int DW = (KICK_DLY > 1) ? $clog2(KICK_DLY) : 1;

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] dly;
    } kick_t;

    kick_t k_d, k_q;

    always_comb begin
        k_d    = k_q;
        fire_o = k_q.pend && (k_q.dly == DW'(KICK_DLY - 1));
        if (!k_q.pend) begin
            if (req_i) begin
                k_d.pend = 1'b1;
                k_d.dly  = '0;
            end
        end else if (fire_o) begin
            k_d.pend = 1'b0;
        end else begin
            k_d.dly = k_q.dly + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    // R7: a pending keepalive is never dropped before it fires
    assert_pend_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (k_q.pend && !fire_o) |=> k_q.pend);
    // R7: an accepted request starts the delay
    assert_req_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!k_q.pend && req_i) |=> k_q.pend);
endmodule

// File: rtl/wdu_countdown.sv
module wdu_countdown
    import wdu_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             sec_mode_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             force_i,
    output logic             expire_o
);
    localparam int PW = $clog2(TICKS_PER_MIN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    pre;
    } cd_t;

    cd_t c_d, c_q;
    logic pre_wrap, step, running, do_reload;

    always_comb begin
        c_d       = c_q;
        running   = (c_q.cnt != '0);
        pre_wrap  = (c_q.pre == PW'(TICKS_PER_MIN - 1));
        step      = tick_i && running && (sec_mode_i || pre_wrap);
        do_reload = reload_i && running;

        if (tick_i && !sec_mode_i)
            c_d.pre = pre_wrap ? '0 : c_q.pre + 1'b1;
        if (step)
            c_d.cnt = c_q.cnt - 1'b1;
        if (do_reload) begin
            c_d.cnt = reload_val_i;
            c_d.pre = '0;
        end
        if (load_i) begin
            c_d.cnt = load_val_i;
            c_d.pre = '0;
        end
        if (force_i)
            c_d.cnt = '0;

        expire_o = force_i ||
                   (step && (c_q.cnt == CNT_W'(1)) && !load_i && !do_reload);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R4: a load sets the count and clears the prescaler
    assert_load_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !force_i) |=> (c_q.cnt == $past(load_val_i) && c_q.pre == '0));
    // R2: after an expiry the count is stopped
    assert_expire_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (c_q.cnt == '0));
    // R2: in seconds mode an undisturbed tick lowers a running count by one
    assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_mode_i && tick_i && running && !load_i && !reload_i && !force_i)
        |=> (c_q.cnt == $past(c_q.cnt) - 1'b1));
    // R3: in minutes mode a tick short of the wrap leaves the count alone
    assert_min_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_mode_i && tick_i && !pre_wrap && !load_i && !reload_i && !force_i)
        |=> $stable(c_q.cnt));
endmodule

// File: rtl/wdu_top.sv
module wdu_top
    import wdu_pkg::*;
#(
    parameter int KICK_DLY      = 1250000,
    parameter int TICKS_PER_MIN = 60,
    parameter bit NARROW        = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1s,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       kick_ir_wr,
    input  logic       kick_gp_rd,
    output logic       wdt_rst,
    output logic       wdt_pg_rst
);
    logic             irk_en, gpk_en, sec_mode, rst_en, pg_en;
    logic             frc, flag, load, fire, expire, kick_req;
    logic [CNT_W-1:0] load_val, reload_val;

    wdu_regs #(.NARROW(NARROW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .expire_i(expire),
        .rdata(reg_rdata), .irk_en_o(irk_en), .gpk_en_o(gpk_en),
        .sec_mode_o(sec_mode), .rst_en_o(rst_en), .pg_en_o(pg_en),
        .force_o(frc), .flag_o(flag), .load_o(load),
        .load_val_o(load_val), .reload_val_o(reload_val)
    );

    assign kick_req = (kick_ir_wr && irk_en) || (kick_gp_rd && gpk_en);

    wdu_kick_delay #(.KICK_DLY(KICK_DLY)) kick_i (
        .clk(clk), .rst_n(rst_n), .req_i(kick_req), .fire_o(fire)
    );

    wdu_countdown #(.TICKS_PER_MIN(TICKS_PER_MIN)) cd_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_1s), .sec_mode_i(sec_mode),
        .load_i(load), .load_val_i(load_val), .reload_i(fire),
        .reload_val_i(reload_val), .force_i(frc), .expire_o(expire)
    );

    assign wdt_rst    = flag && rst_en;
    assign wdt_pg_rst = flag && pg_en;

    // R8: with both enables clear an expiry drives no reset
    assert_test_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_en && !pg_en) |-> (!wdt_rst && !wdt_pg_rst));
endmodule

// File: tb/wdu_top_tb_top.sv
`timescale 1ns/1ps
module wdu_top_tb_top;
    localparam int DLY = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       kir = 1'b0, kgp = 1'b0;
    logic       rst_o, pg_o;
    logic       n_wr = 1'b0, n_rd = 1'b0;
    logic [7:0] n_addr = '0, n_wdata = '0;
    logic [7:0] n_rdata;
    logic       n_rst, n_pg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdu_top #(.KICK_DLY(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick), .reg_wr(wr), .reg_rd(rd),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .kick_ir_wr(kir), .kick_gp_rd(kgp), .wdt_rst(rst_o), .wdt_pg_rst(pg_o)
    );

    wdu_top #(.KICK_DLY(DLY), .NARROW(1'b1)) narrow_i (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick), .reg_wr(n_wr), .reg_rd(n_rd),
        .reg_addr(n_addr), .reg_wdata(n_wdata), .reg_rdata(n_rdata),
        .kick_ir_wr(1'b0), .kick_gp_rd(1'b0), .wdt_rst(n_rst), .wdt_pg_rst(n_pg)
    );

    // vector: {cfg[8], count[16], ticks[16], expect_flag[1]}
    localparam int NV = 10;
    localparam logic [40:0] VEC [NV] = '{
        {8'hC0, 16'd3,     16'd2,   1'b0},
        {8'hC0, 16'd3,     16'd3,   1'b1},
        {8'hD0, 16'h0102,  16'd257, 1'b0},
        {8'hD0, 16'h0102,  16'd258, 1'b1},
        {8'h80, 16'd4,     16'd4,   1'b1},
        {8'h10, 16'd1,     16'd59,  1'b0},
        {8'h10, 16'd1,     16'd60,  1'b1},
        {8'h40, 16'd2,     16'd119, 1'b0},
        {8'h40, 16'd2,     16'd120, 1'b1},
        {8'hC0, 16'd0,     16'd5,   1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        rd = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic flag_is(input string req, input logic exp);
        logic [7:0] v;
        rreg(8'h71, v);
        chk(req, {15'd0, v[0]}, {15'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and address map
        rreg(8'h71, v); chk("R1 reset ctrl", {8'd0, v}, 16'h0);
        rreg(8'h72, v); chk("R1 reset cfg", {8'd0, v}, 16'h0);
        rreg(8'h73, v); chk("R1 reset lo", {8'd0, v}, 16'h0);
        rreg(8'h74, v); chk("R1 reset hi", {8'd0, v}, 16'h0);
        chk("R8 reset outputs", {14'd0, rst_o, pg_o}, 16'h0);
        wreg(8'h72, 8'h8A);
        rreg(8'h72, v); chk("R1 cfg readback incl int-select", {8'd0, v}, 16'h8A);
        rreg(8'h75, v); chk("R1 unmapped reads zero", {8'd0, v}, 16'h0);
        @(negedge clk); addr = 8'h72; rd = 1'b0;
        #1 chk("R1 no read strobe gives zero", {8'd0, rdata}, 16'h0);

        // Table of unit/count/tick vectors: R2 R3 R4 R8
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  cfg;
            logic [15:0] cnt, nt;
            logic        ex;
            cfg = VEC[i][40:33]; cnt = VEC[i][32:17]; nt = VEC[i][16:1]; ex = VEC[i][0];
            wreg(8'h72, cfg);
            wreg(8'h71, 8'h00);
            wreg(8'h74, cnt[15:8]);
            wreg(8'h73, cnt[7:0]);
            pulse_tick(int'(nt));
            flag_is(cfg[7] ? "R2 seconds expiry" : "R3 minutes expiry", ex);
            chk("R8 reset output", {15'd0, rst_o}, {15'd0, ex & cfg[6]});
            chk("R8 power-good reset output", {15'd0, pg_o}, {15'd0, ex & cfg[4]});
        end

        // R5: sticky flag (last expiring state from a fresh run)
        wreg(8'h72, 8'hC0); wreg(8'h71, 8'h00); wreg(8'h74, 8'h00); wreg(8'h73, 8'h01);
        pulse_tick(1);
        flag_is("R2 expiry for sticky test", 1'b1);
        wreg(8'h71, 8'h01);
        flag_is("R5 write 1 keeps flag", 1'b1);
        wreg(8'h71, 8'h00);
        flag_is("R5 write 0 clears flag", 1'b0);
        pulse_tick(3);
        flag_is("R2 stopped counter stays quiet", 1'b0);

        // R4: zero write stops a running count
        wreg(8'h73, 8'h02); pulse_tick(1); wreg(8'h73, 8'h00); pulse_tick(4);
        flag_is("R4 zero write stops", 1'b0);

        // R4: reload clears prescaler
        wreg(8'h72, 8'h40); wreg(8'h73, 8'h01); pulse_tick(30);
        wreg(8'h73, 8'h01); pulse_tick(59);
        flag_is("R4 prescaler cleared by load", 1'b0);
        pulse_tick(1);
        flag_is("R4 minute after reload expires", 1'b1);

        // R6: force
        wreg(8'h72, 8'hC0); wreg(8'h71, 8'h00); wreg(8'h73, 8'h05);
        wreg(8'h71, 8'h02);
        @(negedge clk);
        rreg(8'h71, v);
        chk("R6 force sets flag, bit1 reads 0", {8'd0, v}, 16'h01);
        wreg(8'h71, 8'h00); pulse_tick(6);
        flag_is("R6 force stopped the count", 1'b0);

        // R7: enabled IR keepalive reloads after delay
        wreg(8'h71, 8'h80); wreg(8'h73, 8'h02); pulse_tick(1);
        @(negedge clk); kir = 1'b1; @(negedge clk); kir = 1'b0;
        repeat (DLY + 2) @(negedge clk);
        pulse_tick(1);
        flag_is("R7 IR kick reloaded count", 1'b0);
        pulse_tick(1);
        flag_is("R7 reloaded count expires", 1'b1);

        // R7: tick inside the delay still hits the old count; no restart after
        wreg(8'h71, 8'h80); wreg(8'h73, 8'h02); pulse_tick(1);
        @(negedge clk); kir = 1'b1; @(negedge clk); kir = 1'b0;
        pulse_tick(1);
        flag_is("R7 reload is delayed", 1'b1);
        repeat (DLY + 2) @(negedge clk);
        wreg(8'h71, 8'h80); pulse_tick(3);
        flag_is("R7 late reload ignored when stopped", 1'b0);

        // R7: disabled source ignored
        wreg(8'h71, 8'h00); wreg(8'h73, 8'h02); pulse_tick(1);
        @(negedge clk); kir = 1'b1; kgp = 1'b1; @(negedge clk); kir = 1'b0; kgp = 1'b0;
        repeat (DLY + 2) @(negedge clk);
        pulse_tick(1);
        flag_is("R7 disabled kick ignored", 1'b1);

        // R7: game port source
        wreg(8'h71, 8'h10); wreg(8'h73, 8'h02); pulse_tick(1);
        @(negedge clk); kgp = 1'b1; @(negedge clk); kgp = 1'b0;
        repeat (DLY + 2) @(negedge clk);
        pulse_tick(1);
        flag_is("R7 GP kick reloaded count", 1'b0);

        // R9: narrow variant
        @(negedge clk); n_wr = 1'b1; n_addr = 8'h72; n_wdata = 8'hC0;
        @(negedge clk); n_addr = 8'h74; n_wdata = 8'h01;
        @(negedge clk); n_addr = 8'h73; n_wdata = 8'h02;
        @(negedge clk); n_wr = 1'b0; n_rd = 1'b1; n_addr = 8'h74;
        #1 chk("R9 high byte reads zero", {8'd0, n_rdata}, 16'h0);
        n_rd = 1'b0;
        pulse_tick(2);
        @(negedge clk); n_rd = 1'b1; n_addr = 8'h71;
        #1 chk("R9 8-bit count expires", {15'd0, n_rdata[0]}, 16'h1);
        n_rd = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule